// File: doc/BRIEF.md
# Self-Gating Clock Controller for an I2C Master

This block decides when an I2C master controller gets a clock. The master's bit engine reports each STOP condition it has put on the bus. When that report arrives during a transfer, the controller drops the clock enable on the next edge, with no action from software. The clock gate cell is outside this block and is driven by the enable output.

Before software programs the master for its next transfer, it writes a wake request. The clock then comes back, and a settle counter runs for a fixed number of cycles while the restored clock is treated as unstable. A start-transfer request that arrives during that interval is held. It is released as a one-cycle start pulse once the block reports ready. A request that arrives after ready is released the same way.

One case needs care: a second bus agent reuses the master right after the first one finishes. The clock stops and restarts within a few cycles, and the block handles this like any other wake. If the wake request arrives in the same cycle as the STOP report, the clock stays on, and the block goes straight back to ready without settling.

Top module: `i2c_autogate`

## Requirements
- R1: While reset is high and on the first cycle after it, `clk_en`, `ready` and `xfer_go` are all low, and the block is in its clock-off state.
- R2: During a transfer, a `stop_done` pulse without `wake_req` drives `clk_en` and `ready` low from the next cycle.
- R3: During a transfer, a `stop_done` and a `wake_req` in the same cycle keep `clk_en` high, and `ready` rises on the next cycle without any settle interval.
- R4: A `wake_req` while the clock is off raises `clk_en` on the next cycle. `ready` then rises exactly `SETTLE_CYC` cycles after the cycle in which `wake_req` was sampled.
- R5: A `xfer_req` pulse during the settle interval is held and never dropped. `xfer_go` pulses for one cycle, one cycle after `ready` rises.
- R6: A `xfer_req` while `ready` is high gives a one-cycle `xfer_go` pulse on the next cycle. In that same cycle `ready` falls and `clk_en` stays high.
- R7: `clk_en` falls only on the cycle after a `stop_done` sampled during a transfer. A `stop_done` while off, settling or ready has no effect.
- R8: A `xfer_req` while the clock is off has no effect. It is not remembered, and no `xfer_go` follows once the block later becomes ready.
- R9: A `wake_req` while settling, ready or transferring without `stop_done` has no effect. In particular, it does not restart the settle interval.
- R10: A STOP report followed by a `wake_req` one cycle later runs a full settle interval, and a transfer can then be started normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock for the controller (ungated side) |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Software request to restore the master's clock, one-cycle pulse |
| stop_done | input | 1 | Strobe from the bit engine: a STOP condition has been generated |
| xfer_req | input | 1 | Request to begin a new transfer, one-cycle pulse |
| clk_en | output | 1 | Enable for the external clock gate cell |
| ready | output | 1 | Clock is on and settled, and no transfer is running |
| xfer_go | output | 1 | One-cycle pulse that starts the bit engine |

## Verification
Two collisions matter. A wake request can land in the same cycle as a STOP report. A start request can land inside the settle interval while the counter is still running. The bench drives the block into each of the four states and applies all eight combinations of `wake_req`, `stop_done` and `xfer_req` for one cycle. It judges the immediate outputs, and then judges an idle follow-up window of `SETTLE_CYC`+1 cycles. The follow-up window shows whether the block went back to ready, whether a held start was released, and whether the clock went off. A separate directed case issues a STOP report and then a wake request on the next cycle, counts the settle cycles, and starts a transfer afterwards.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2,
        ST_ACTIVE = 2'd3
    } agc_state_e;

    typedef struct packed {
        logic wake;
        logic stop;
        logic xfer;
    } agc_req_t;

    function automatic logic clock_needed(input agc_state_e s);
        return s != ST_OFF;
    endfunction

endpackage

// File: rtl/agc_settle_timer.sv
module agc_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || load)
            cnt <= '0;
        else if (run && !done)
            cnt <= cnt + 1'b1;
    end

    // R4: the count never passes its terminal value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/agc_req_hold.sv
module agc_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end

    // R5: a request captured while settling is kept
    a_r5_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> q);

endmodule

// File: rtl/i2c_autogate.sv
module i2c_autogate
    import agc_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wake_req,
    input  logic stop_done,
    input  logic xfer_req,
    output logic clk_en,
    output logic ready,
    output logic xfer_go
);
    localparam int OW = $clog2(SETTLE_CYC + 2);

    agc_state_e state, nxt;
    agc_req_t   req;
    logic       settle_done, pend, go_now, load_timer, hold_set;

    assign req = '{wake: wake_req, stop: stop_done, xfer: xfer_req};

    assign load_timer = (state == ST_OFF) && req.wake;
    assign hold_set   = (state == ST_SETTLE) && req.xfer;
    assign go_now     = (state == ST_READY) && (pend || req.xfer);

    agc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (load_timer),
        .run  (state == ST_SETTLE),
        .done (settle_done)
    );

    agc_req_hold u_hold (
        .clk (clk),
        .rst (rst),
        .set (hold_set),
        .clr (go_now),
        .q   (pend)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (req.wake) nxt = ST_SETTLE;
            ST_SETTLE: if (settle_done) nxt = ST_READY;
            ST_READY:  if (go_now) nxt = ST_ACTIVE;
            ST_ACTIVE: if (req.stop) nxt = req.wake ? ST_READY : ST_OFF;
            default:   nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            xfer_go <= 1'b0;
        end else begin
            state   <= nxt;
            xfer_go <= go_now;
        end
    end

    assign clk_en = clock_needed(state);
    assign ready  = (state == ST_READY);

    // independent observer of time spent settling
    logic [OW-1:0] settle_obs;
    always_ff @(posedge clk) begin
        if (rst || state != ST_SETTLE)
            settle_obs <= '0;
        else
            settle_obs <= settle_obs + 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!clk_en && !ready && !xfer_go));

    a_r2_stop_gates: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && stop_done && !wake_req) |=> (!clk_en && !ready));

    a_r3_wake_wins: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && stop_done && wake_req) |=> (clk_en && ready));

    a_r4_wake_clock: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && wake_req) |=> (clk_en && !ready));

    a_r4_settle_len: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && $past(state) == ST_SETTLE) |-> (settle_obs == OW'(SETTLE_CYC)));

    a_r6_go_from_ready: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> ($past(ready) && !ready && clk_en));

    a_r7_gate_after_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> $past(stop_done));

    a_r4_ready_clocked: assert property (@(posedge clk) disable iff (rst)
        ready |-> clk_en);

endmodule

// File: tb/i2c_autogate_test.sv
module i2c_autogate_test;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst, w, s, x;
    logic clk_en, ready, xfer_go;
    int   checks = 0;
    int   fails  = 0;

    always #4 clk = ~clk;

    i2c_autogate #(.SETTLE_CYC(S)) uut (
        .clk(clk), .rst(rst), .wake_req(w), .stop_done(s), .xfer_req(x),
        .clk_en(clk_en), .ready(ready), .xfer_go(xfer_go)
    );

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {clk_en,ready,go} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic a, input logic b, input logic c);
        w = a; s = b; x = c;
        @(posedge clk);
        #1;
        w = 1'b0; s = 1'b0; x = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; w = 1'b0; s = 1'b0; x = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 during reset", {clk_en, ready, xfer_go}, 3'b000);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 after reset", {clk_en, ready, xfer_go}, 3'b000);
    endtask

    // 0 off, 1 settling (first cycle), 2 ready, 3 active
    task automatic goto_state(input int st);
        do_reset();
        if (st >= 1) cyc(1'b1, 1'b0, 1'b0);
        if (st >= 2) repeat (S) cyc(1'b0, 1'b0, 1'b0);
        if (st == 3) cyc(1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // near-exhaustive sweep: every state x every input combination
        for (int st = 0; st < 4; st++) begin
            for (int v = 0; v < 8; v++) begin
                logic a, b, c, seen;
                logic [2:0] e1, e2;
                string tag;
                a = v[2]; b = v[1]; c = v[0];
                case (st)
                    0: begin e1 = a ? 3'b100 : 3'b000; e2 = a ? 3'b110 : 3'b000;
                             tag = "R8/R4 off"; end
                    1: begin e1 = 3'b100; e2 = c ? 3'b101 : 3'b110;
                             tag = "R5/R7/R9 settling"; end
                    2: begin e1 = c ? 3'b101 : 3'b110; e2 = c ? 3'b100 : 3'b110;
                             tag = "R6/R7/R9 ready"; end
                    default: begin
                        e1 = (a && b) ? 3'b110 : (b ? 3'b000 : 3'b100);
                        e2 = e1;
                        tag = "R2/R3/R9 active";
                    end
                endcase
                goto_state(st);
                cyc(a, b, c);
                chk($sformatf("%s now v=%0d", tag, v), {clk_en, ready, xfer_go}, e1);
                seen = 1'b0;
                repeat (S + 1) begin
                    cyc(1'b0, 1'b0, 1'b0);
                    if (xfer_go) seen = 1'b1;
                end
                chk($sformatf("%s later v=%0d", tag, v), {clk_en, ready, seen}, e2);
            end
        end

        // R4: exact settle length
        begin
            int n;
            goto_state(0);
            cyc(1'b1, 1'b0, 1'b0);
            n = 0;
            while (!ready && n < 20) begin cyc(1'b0, 1'b0, 1'b0); n++; end
            chk("R4 settle cycles", n[2:0], 3'(S));
        end

        // R10: back-to-back reuse
        begin
            int n;
            goto_state(3);
            cyc(1'b0, 1'b1, 1'b0);
            chk("R10 stop gates", {clk_en, ready, xfer_go}, 3'b000);
            cyc(1'b1, 1'b0, 1'b0);
            chk("R10 wake", {clk_en, ready, xfer_go}, 3'b100);
            n = 0;
            while (!ready && n < 20) begin cyc(1'b0, 1'b0, 1'b0); n++; end
            chk("R10 resettle", n[2:0], 3'(S));
            cyc(1'b0, 1'b0, 1'b1);
            chk("R10 restart", {clk_en, ready, xfer_go}, 3'b101);
        end

        // R9: repeated wake mid-settle does not extend the interval
        begin
            int n;
            goto_state(0);
            cyc(1'b1, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0);
            cyc(1'b1, 1'b0, 1'b0);
            n = 2;
            while (!ready && n < 20) begin cyc(1'b0, 1'b0, 1'b0); n++; end
            chk("R9 no restart", n[2:0], 3'(S));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule